// File: doc/BRIEF.md
# Comparator Pin Group Input Router

This block sits between a three-pin input group of a microcontroller port and the logic that consumes those pins. A single mode bit selects how the group is read. In analog mode the first two pins are read through comparators and the third pin acts as their shared reference level. In digital mode all three pins are plain inputs. The block drives the group's three input-register bits, an interrupt request tied to the third bit, a wake request for leaving stop mode, and the levels on two output pins. Each output pin can carry a comparator result in place of ordinary port data.

In analog mode the third register bit is not a pin level. It is the combined level of the stop-recovery wake sources, which are active low, and the three group pins are left out of that combination. Comparators are treated as powered down in stop mode, so their results read as 0 there. The group pins can wake the part only while the group is in digital mode. Comparator results arrive as digital inputs. Pin drivers and the interrupt controller live outside the block.

Top module: `cmp_port_router`

## Requirements
- R1: Pin levels, comparator results and wake sources pass through a two-flop synchroniser and an output register, so they reach the outputs three clock edges after they change. `analog_mode`, `stop_mode`, `route_ctl` and `port_out_data` take effect one edge after they change.
- R2: In digital mode (`analog_mode`=0), `in_bits[i]` equals the synchronised level of `pin_lvl[i]` for i = 0, 1, 2. Bit 2 is the third pin's register bit.
- R3: In analog mode, `in_bits[1:0]` equal the comparator results `cmp_res[1:0]`. `in_bits[2]` equals the AND of all `wake_src_n` bits. The levels on `pin_lvl` have no effect on `in_bits`.
- R4: `d3_irq` is a one-cycle pulse in the same cycle that `in_bits[2]` falls from 1 to 0. A rising edge of `in_bits[2]` raises no pulse.
- R5: `d3_irq` stays low in the cycle in which the registered mode changes, even when `in_bits[2]` falls in that cycle.
- R6: While `stop_mode` is 1, comparator results are forced to 0. In analog mode this makes `in_bits[1:0]` 0, and every output pin routed to a comparator goes to 0.
- R7: `wake_req` is 1 only while `stop_mode` is 1 and at least one wake source reads low. A wake source is a bit of `wake_src_n`, or a bit of `pin_lvl` when the group is in digital mode. Group pins never wake the part in analog mode.
- R8: When `analog_mode` is 1 and `route_ctl[i]` is 1, `out_pin[i]` carries comparator result i. Otherwise `out_pin[i]` carries `port_out_data[i]`.
- R9: During and right after reset, `in_bits` is 3'b111, and `d3_irq`, `wake_req` and `out_pin` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| analog_mode | input | 1 | 1 = comparator mode, 0 = digital mode |
| stop_mode | input | 1 | Part is in stop mode |
| route_ctl | input | 2 | Per output pin: route comparator result to it |
| port_out_data | input | 2 | Normal port data for the two output pins |
| pin_lvl | input | 3 | Raw levels of the three group pins |
| cmp_res | input | 2 | Comparator results for the first two pins |
| wake_src_n | input | WAKE_W | Other stop-recovery sources, active low |
| in_bits | output | 3 | Group bits of the port input register |
| d3_irq | output | 1 | Interrupt pulse from the third bit |
| wake_req | output | 1 | Stop-mode wake request |
| out_pin | output | 2 | Levels for the two output pins |

## Verification
A wrong source select shows up directly on `in_bits`. It appears three edges after an input change, or one edge after a mode switch. A stale edge-detect register shows up as a missing pulse or a spurious `d3_irq` pulse in the cycle that `in_bits[2]` moves, including the cycle of a mode switch. The stop-mode gating and the routing selects surface on `wake_req` and `out_pin` one edge after the control changes. The bench therefore samples each outcome in its exact cycle, and also one cycle early to confirm the latency.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

    localparam int GRP_PINS = 3;
    localparam int CMP_N    = 2;

    typedef struct packed {
        logic [GRP_PINS-1:0] bits;
        logic                mode;
        logic                irq;
        logic                wake;
        logic [CMP_N-1:0]    outp;
    } cpr_state_t;

    localparam cpr_state_t ST_RST = '{
        bits: '1,
        mode: 1'b0,
        irq:  1'b0,
        wake: 1'b0,
        outp: '0
    };

endpackage

// File: rtl/cpr_sync.sv
module cpr_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter bit RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam logic [W-1:0] RST_V = RST_ONE ? '1 : '0;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_V;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cpr_wake.sv
module cpr_wake #(
    parameter int WAKE_W = 4,
    parameter int PINS   = 3
) (
    input  logic [WAKE_W-1:0] wake_s,
    input  logic [PINS-1:0]   pin_s,
    input  logic              digital,
    output logic              smr_level,
    output logic              any_low
);
    logic pins_low;

    always_comb begin
        smr_level = &wake_s;
        pins_low  = digital & ~(&pin_s);
        any_low   = ~smr_level | pins_low;
    end
endmodule

// File: rtl/cpr_route.sv
module cpr_route #(
    parameter int N = 2
) (
    input  logic [N-1:0] cmp_eff,
    input  logic [N-1:0] port_data,
    input  logic [N-1:0] sel,
    output logic [N-1:0] pin_out
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        assign pin_out[g] = sel[g] ? cmp_eff[g] : port_data[g];
    end
endmodule

// File: rtl/cmp_port_router.sv
module cmp_port_router
    import cpr_pkg::*;
#(
    parameter int WAKE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                analog_mode,
    input  logic                stop_mode,
    input  logic [CMP_N-1:0]    route_ctl,
    input  logic [CMP_N-1:0]    port_out_data,
    input  logic [GRP_PINS-1:0] pin_lvl,
    input  logic [CMP_N-1:0]    cmp_res,
    input  logic [WAKE_W-1:0]   wake_src_n,
    output logic [GRP_PINS-1:0] in_bits,
    output logic                d3_irq,
    output logic                wake_req,
    output logic [CMP_N-1:0]    out_pin
);
    localparam int D3 = GRP_PINS - 1;

    logic [GRP_PINS-1:0] pin_s;
    logic [CMP_N-1:0]    cmp_s, cmp_eff, route_sel, route_out;
    logic [WAKE_W-1:0]   wake_s;
    logic                smr_level, any_low;

    cpr_state_t st_d, st_q;

    cpr_sync #(.W(GRP_PINS), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .din(pin_lvl), .dout(pin_s)
    );
    cpr_sync #(.W(CMP_N), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_sync_cmp (
        .clk(clk), .rst_n(rst_n), .din(cmp_res), .dout(cmp_s)
    );
    cpr_sync #(.W(WAKE_W), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync_wake (
        .clk(clk), .rst_n(rst_n), .din(wake_src_n), .dout(wake_s)
    );

    cpr_wake #(.WAKE_W(WAKE_W), .PINS(GRP_PINS)) u_wake (
        .wake_s(wake_s), .pin_s(pin_s), .digital(~analog_mode),
        .smr_level(smr_level), .any_low(any_low)
    );

    assign cmp_eff   = stop_mode ? '0 : cmp_s;
    assign route_sel = route_ctl & {CMP_N{analog_mode}};

    cpr_route #(.N(CMP_N)) u_route (
        .cmp_eff(cmp_eff), .port_data(port_out_data),
        .sel(route_sel), .pin_out(route_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = analog_mode;
        for (int i = 0; i < D3; i++) begin
            st_d.bits[i] = analog_mode ? cmp_eff[i] : pin_s[i];
        end
        st_d.bits[D3] = analog_mode ? smr_level : pin_s[D3];
        // falling edge of the third bit, masked when the source select switches
        st_d.irq  = st_q.bits[D3] & ~st_d.bits[D3] & (analog_mode == st_q.mode);
        st_d.wake = stop_mode & any_low;
        st_d.outp = route_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_bits  = st_q.bits;
    assign d3_irq   = st_q.irq;
    assign wake_req = st_q.wake;
    assign out_pin  = st_q.outp;
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       analog_mode,
    input logic       stop_mode,
    input logic [1:0] route_ctl,
    input logic [1:0] port_out_data,
    input logic [2:0] in_bits,
    input logic       d3_irq,
    input logic       wake_req,
    input logic [1:0] out_pin
);
    p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        d3_irq |-> (!in_bits[2] && $past(in_bits[2])));

    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        d3_irq |=> !d3_irq);

    p_no_irq_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_mode != $past(analog_mode)) |=> !d3_irq);

    p_wake_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(stop_mode));

    p_stop_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_mode) && $past(analog_mode)) |-> (in_bits[1:0] == 2'b00));

    p_stop_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_mode) && $past(analog_mode) && $past(route_ctl[0])) |-> !out_pin[0]);

    p_route_off0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(analog_mode) && $past(route_ctl[0])) |-> (out_pin[0] == $past(port_out_data[0])));

    p_route_off1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(analog_mode) && $past(route_ctl[1])) |-> (out_pin[1] == $past(port_out_data[1])));
endmodule

bind cmp_port_router cpr_checker u_cpr_checker (
    .clk(clk), .rst_n(rst_n), .analog_mode(analog_mode), .stop_mode(stop_mode),
    .route_ctl(route_ctl), .port_out_data(port_out_data), .in_bits(in_bits),
    .d3_irq(d3_irq), .wake_req(wake_req), .out_pin(out_pin)
);

// File: tb/test_cmp_port_router.sv
`timescale 1ns/1ps
module test_cmp_port_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       analog_mode = 1'b0, stop_mode = 1'b0;
    logic [1:0] route_ctl = 2'b00, port_out_data = 2'b00, cmp_res = 2'b00;
    logic [2:0] pin_lvl = 3'b111;
    logic [3:0] wake_src_n = 4'b1111;
    logic [2:0] in_bits;
    logic       d3_irq, wake_req;
    logic [1:0] out_pin;

    always #2 clk = ~clk;

    cmp_port_router i_cmp_port_router (
        .clk(clk), .rst_n(rst_n), .analog_mode(analog_mode), .stop_mode(stop_mode),
        .route_ctl(route_ctl), .port_out_data(port_out_data), .pin_lvl(pin_lvl),
        .cmp_res(cmp_res), .wake_src_n(wake_src_n), .in_bits(in_bits),
        .d3_irq(d3_irq), .wake_req(wake_req), .out_pin(out_pin)
    );

    // observation word: [6] irq, [5] wake, [4:3] out_pin, [2:0] in_bits
    typedef struct {
        int         at;
        logic [6:0] mask;
        logic [6:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int dly, logic [6:0] mask, logic [6:0] exp, string req);
        item_t it;
        it.at = cyc + dly; it.mask = mask; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: compare queued expectations in their cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].at <= cyc) begin
                item_t it;
                logic [6:0] obs;
                it  = q.pop_front();
                obs = {d3_irq, wake_req, out_pin, in_bits};
                n_cmp++;
                if (it.at != cyc || (obs & it.mask) != (it.exp & it.mask)) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b (mask %b) cycle %0d",
                             it.req, obs & it.mask, it.exp & it.mask, it.mask, cyc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        step(3);
        // R9 reset values while reset is held
        n_cmp++;
        if ({d3_irq, wake_req, out_pin, in_bits} != 7'b0000111) begin
            n_bad++;
            $display("FAIL R9: actual %b expected %b", {d3_irq, wake_req, out_pin, in_bits}, 7'b0000111);
        end
        rst_n = 1'b1;
        expect_at(1, 7'b1111111, 7'b0000111, "R9");
        step(5);

        // R2 / R1 / R4 digital: third pin falls
        pin_lvl = 3'b010;
        expect_at(2, 7'b1000111, 7'b0000111, "R1");
        expect_at(3, 7'b1000111, 7'b1000010, "R2");
        expect_at(4, 7'b1000000, 7'b0000000, "R4");
        step(5);
        pin_lvl = 3'b111;
        expect_at(3, 7'b1000111, 7'b0000111, "R4");
        step(5);

        // R3 analog: comparators on bits 1:0, wake AND on bit 2
        analog_mode = 1'b1; cmp_res = 2'b01;
        expect_at(1, 7'b0000111, 7'b0000100, "R1");
        expect_at(3, 7'b0000111, 7'b0000101, "R3");
        step(5);
        pin_lvl = 3'b000;
        expect_at(3, 7'b1100111, 7'b0000101, "R3");
        step(5);

        // R5 switch to digital while third pin is low
        analog_mode = 1'b0;
        expect_at(1, 7'b1000111, 7'b0000000, "R5");
        expect_at(2, 7'b1000000, 7'b0000000, "R5");
        step(5);
        pin_lvl = 3'b111; analog_mode = 1'b1;
        step(5);

        // R4 analog: a wake source drops bit 2
        wake_src_n = 4'b1101;
        expect_at(3, 7'b1100100, 7'b1000000, "R4");
        expect_at(4, 7'b1000000, 7'b0000000, "R4");
        step(5);
        wake_src_n = 4'b1111;
        step(5);

        // R8 routing then R6 stop forcing
        cmp_res = 2'b11; route_ctl = 2'b11;
        expect_at(3, 7'b0011111, 7'b0011111, "R8");
        step(5);
        stop_mode = 1'b1;
        expect_at(1, 7'b0111011, 7'b0000000, "R6");
        step(5);

        // R7 wake in stop
        pin_lvl = 3'b110;
        expect_at(3, 7'b0100000, 7'b0000000, "R7");
        step(5);
        wake_src_n = 4'b1011;
        expect_at(3, 7'b0100000, 7'b0100000, "R7");
        step(5);
        wake_src_n = 4'b1111;
        expect_at(3, 7'b0100000, 7'b0000000, "R7");
        step(5);
        analog_mode = 1'b0;
        expect_at(1, 7'b0111000, 7'b0100000, "R7");
        step(5);
        stop_mode = 1'b0;
        expect_at(1, 7'b0100000, 7'b0000000, "R7");
        step(5);

        // R8 per-pin routing
        pin_lvl = 3'b111; analog_mode = 1'b1; cmp_res = 2'b10; route_ctl = 2'b00;
        step(5);
        route_ctl = 2'b01; port_out_data = 2'b11;
        expect_at(1, 7'b0011000, 7'b0010000, "R8");
        step(3);
        route_ctl = 2'b10; port_out_data = 2'b01;
        expect_at(1, 7'b0011000, 7'b0011000, "R8");
        step(3);
        analog_mode = 1'b0; route_ctl = 2'b11; port_out_data = 2'b10;
        expect_at(1, 7'b0011000, 7'b0010000, "R8");
        step(3);

        while (q.size() > 0) step(1);
        step(1);
        report();
    end
endmodule